// File: doc/BRIEF.md
# Extended Configuration Switch Executor

This block is the card-side executor for the switch command (command index 6). When a command with that index arrives on a valid strobe, the block decodes the 32-bit argument and applies a one-byte update to a 512-byte extended configuration array. It can also change the active command set instead of touching the array. Each update picks one of four access modes: replace the byte, OR bits in, clear bits, or change the command set. Only a small set of configuration bytes may be written. A switch that targets any other byte, that leaves the bus-width byte holding an undefined code, or that has nonzero reserved argument bits changes nothing and raises the error flag.

After each switch it takes, the executor reports busy for a programmable number of cycles. Switch commands that arrive while busy is high are dropped. A combinational read port gives the surrounding card logic access to every byte of the array. Command framing, CRC and the data transfer that streams the array out are handled elsewhere.

Top module: `cfg_switch_exec`

## Requirements
- R1: In the cycle after a synchronous reset, busy, switch_err and cmd_set are 0. Bytes 175, 183 and 185 read 0x00, byte 192 reads 0x05, byte 194 reads 0x02 and byte 196 reads 0x03. Bytes 212..215 hold SEC_COUNT least-significant byte first (default 0x00EC8000, so 0x00, 0x80, 0xEC, 0x00). Each byte n in 217..232 reads n-200, and every other byte reads 0x00.
- R2: A switch is taken only when cmd_valid is high, cmd_index equals 6 and busy is low. The argument fields are: mode in [25:24], byte index in [23:16], value in [15:8] and command set in [2:0]. A strobe with any other index changes nothing.
- R3: Mode 3 replaces the target byte with the value byte. The new content is visible on the read port in the cycle after the switch is taken.
- R4: Mode 1 sets the target bits that are 1 in the value byte (target OR value).
- R5: Mode 2 clears the target bits that are 1 in the value byte (target AND NOT value).
- R6: Mode 0 loads cmd_set from argument bits [2:0] and leaves the array unchanged. cmd_set changes at no other time.
- R7: A switch with any of argument bits [31:26] or [7:3] set is rejected.
- R8: A switch in mode 1, 2 or 3 whose byte index is anything other than 175, 183 or 185 is rejected. For example, 192 and 213 are read-only.
- R9: A switch in mode 1, 2 or 3 on byte 183 is rejected if the resulting byte would not be 0, 1, 2, 5 or 6.
- R10: Busy is high for exactly BUSY_CYCLES cycles (default 8), starting in the cycle after a switch is taken, whether or not that switch was rejected. A switch presented while busy is high is ignored: no array change, no cmd_set change and no change to switch_err.
- R11: In the cycle after a switch is taken, switch_err is 1 if that switch was rejected and 0 otherwise. It holds that value until the next switch is taken. A rejected switch changes neither the array nor cmd_set.
- R12: rd_data shows the byte at rd_addr combinationally, over all 512 addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_index | input | 6 | Command index; 6 selects a switch |
| cmd_arg | input | 32 | Switch argument |
| busy | output | 1 | High while the executor refuses new switches |
| switch_err | output | 1 | Result of the most recently taken switch |
| cmd_set | output | 3 | Active command set |
| rd_addr | input | 9 | Read port byte address |
| rd_data | output | 8 | Byte at rd_addr |

## Verification
The state is small: the byte array, the busy counter, the error flag and the command-set register. Each one appears at a port within one cycle of the switch that changes it. A wrong byte shows on the read port in the cycle after the faulty switch. A wrong busy count moves the falling edge of busy, which shows in how many cycles busy stays high. It also shows when a switch issued right after the window is taken or dropped. A leaked write on a rejected or dropped switch shows up when the bench reads back the target byte, and the tests cover modes, reserved bits, protected bytes and bus-width codes.

// File: rtl/cfg_switch_pkg.sv
package cfg_switch_pkg;

    typedef enum logic [1:0] {
        AM_CMDSET  = 2'd0,
        AM_SETBITS = 2'd1,
        AM_CLRBITS = 2'd2,
        AM_WRITE   = 2'd3
    } access_mode_e;

    typedef struct packed {
        access_mode_e mode;
        logic [7:0]   index;
        logic [7:0]   value;
        logic [2:0]   cset;
        logic         rsvd_bad;
    } switch_req_t;

    localparam logic [5:0] SWITCH_CMD_IDX = 6'd6;
    localparam logic [7:0] IDX_ERASE_GRP  = 8'd175;
    localparam logic [7:0] IDX_BUS_WIDTH  = 8'd183;
    localparam logic [7:0] IDX_HS_TIMING  = 8'd185;

    function automatic switch_req_t unpack_arg(input logic [31:0] a);
        switch_req_t r;
        r.mode     = access_mode_e'(a[25:24]);
        r.index    = a[23:16];
        r.value    = a[15:8];
        r.cset     = a[2:0];
        r.rsvd_bad = (|a[31:26]) | (|a[7:3]);
        return r;
    endfunction

    function automatic logic bus_width_legal(input logic [7:0] c);
        return (c == 8'd0) || (c == 8'd1) || (c == 8'd2) ||
               (c == 8'd5) || (c == 8'd6);
    endfunction

    function automatic logic is_writable(input logic [7:0] idx);
        return (idx == IDX_ERASE_GRP) || (idx == IDX_BUS_WIDTH) ||
               (idx == IDX_HS_TIMING);
    endfunction

    function automatic logic [7:0] default_byte(input int idx, input logic [31:0] sec);
        logic [7:0] b;
        b = 8'h00;
        if (idx == 192)      b = 8'h05;
        else if (idx == 194) b = 8'h02;
        else if (idx == 196) b = 8'h03;
        else if (idx == 212) b = sec[7:0];
        else if (idx == 213) b = sec[15:8];
        else if (idx == 214) b = sec[23:16];
        else if (idx == 215) b = sec[31:24];
        else if (idx >= 217 && idx <= 232) b = 8'(idx - 200);
        return b;
    endfunction

endpackage

// File: rtl/switch_decode.sv
module switch_decode
    import cfg_switch_pkg::*;
(
    input  logic [31:0] arg,
    output switch_req_t req,
    output logic        target_ok
);
    always_comb begin
        req       = unpack_arg(arg);
        target_ok = is_writable(req.index);
    end
endmodule

// File: rtl/switch_alu.sv
module switch_alu
    import cfg_switch_pkg::*;
(
    input  switch_req_t req,
    input  logic [7:0]  cur_byte,
    output logic [7:0]  new_byte,
    output logic        result_ok
);
    always_comb begin
        unique case (req.mode)
            AM_SETBITS: new_byte = cur_byte | req.value;
            AM_CLRBITS: new_byte = cur_byte & ~req.value;
            AM_WRITE:   new_byte = req.value;
            default:    new_byte = cur_byte;
        endcase
        if (req.index == IDX_BUS_WIDTH)
            result_ok = bus_width_legal(new_byte);
        else
            result_ok = 1'b1;
    end
endmodule

// File: rtl/ext_reg_array.sv
module ext_reg_array
    import cfg_switch_pkg::*;
#(
    parameter int          NUM_BYTES = 512,
    parameter int          ADDR_W    = $clog2(NUM_BYTES),
    parameter logic [31:0] SEC_COUNT = 32'h00EC_8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic [7:0]        cur_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    logic [7:0] mem [NUM_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BYTES; i++)
                mem[i] <= default_byte(i, SEC_COUNT);
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign cur_data = mem[cur_addr];
    assign rd_data  = mem[rd_addr];

    // R3 / R11: without a write strobe, the byte seen at a steady address holds
    assert_hold_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (rd_addr != $past(rd_addr)) || (rd_data == $past(rd_data)));
endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
    parameter int BUSY_CYCLES = 8,
    parameter int CNT_W       = $clog2(BUSY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (start)      cnt <= LOAD;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    assert_busy_after_take_R10: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);
    assert_no_drop_on_take_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !$past(start));
endmodule

// File: rtl/cfg_switch_exec.sv
module cfg_switch_exec
    import cfg_switch_pkg::*;
#(
    parameter int          NUM_BYTES   = 512,
    parameter int          ADDR_W      = $clog2(NUM_BYTES),
    parameter int          BUSY_CYCLES = 8,
    parameter logic [31:0] SEC_COUNT   = 32'h00EC_8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [5:0]        cmd_index,
    input  logic [31:0]       cmd_arg,
    output logic              busy,
    output logic              switch_err,
    output logic [2:0]        cmd_set,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    switch_req_t       req;
    logic              target_ok;
    logic [7:0]        cur_byte;
    logic [7:0]        new_byte;
    logic              result_ok;
    logic              take;
    logic              reject;
    logic              wr_en;
    logic [ADDR_W-1:0] tgt_addr;

    switch_decode u_decode (
        .arg       (cmd_arg),
        .req       (req),
        .target_ok (target_ok)
    );

    assign tgt_addr = ADDR_W'(req.index);

    switch_alu u_alu (
        .req       (req),
        .cur_byte  (cur_byte),
        .new_byte  (new_byte),
        .result_ok (result_ok)
    );

    ext_reg_array #(
        .NUM_BYTES (NUM_BYTES),
        .ADDR_W    (ADDR_W),
        .SEC_COUNT (SEC_COUNT)
    ) u_array (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (tgt_addr),
        .wr_data  (new_byte),
        .cur_addr (tgt_addr),
        .cur_data (cur_byte),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    busy_timer #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (take),
        .busy  (busy)
    );

    always_comb begin
        take   = cmd_valid && (cmd_index == SWITCH_CMD_IDX) && !busy;
        reject = req.rsvd_bad ||
                 ((req.mode != AM_CMDSET) && (!target_ok || !result_ok));
        wr_en  = take && !reject && (req.mode != AM_CMDSET);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            switch_err <= 1'b0;
            cmd_set    <= 3'd0;
        end else if (take) begin
            switch_err <= reject;
            if (!reject && req.mode == AM_CMDSET)
                cmd_set <= req.cset;
        end
    end

    assert_err_on_reject_R11: assert property (@(posedge clk) disable iff (rst)
        (take && reject) |=> switch_err);
    assert_err_clear_on_accept_R11: assert property (@(posedge clk) disable iff (rst)
        (take && !reject) |=> !switch_err);
    assert_cmdset_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(cmd_set));
    assert_err_hold_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(switch_err));
endmodule

// File: tb/cfg_switch_exec_tb_top.sv
`timescale 1ns/1ps
module cfg_switch_exec_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [5:0]  cmd_index = 6'd0;
    logic [31:0] cmd_arg = 32'd0;
    logic        busy;
    logic        switch_err;
    logic [2:0]  cmd_set;
    logic [8:0]  rd_addr = 9'd0;
    logic [7:0]  rd_data;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    cfg_switch_exec dut_i (
        .clk (clk), .rst (rst), .cmd_valid (cmd_valid), .cmd_index (cmd_index),
        .cmd_arg (cmd_arg), .busy (busy), .switch_err (switch_err),
        .cmd_set (cmd_set), .rd_addr (rd_addr), .rd_data (rd_data)
    );

    function automatic logic [31:0] mk(input logic [1:0] m, input logic [7:0] idx,
                                       input logic [7:0] val, input logic [2:0] cs);
        return {6'b0, m, idx, val, 5'b0, cs};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic peek(input int a, output logic [7:0] d);
        rd_addr = 9'(a);
        #0.5;
        d = rd_data;
    endtask

    task automatic check_byte(input string req, input int a, input logic [7:0] exp);
        logic [7:0] d;
        peek(a, d);
        check(req, {24'd0, d}, {24'd0, exp});
    endtask

    // drive at a falling edge; returns at the falling edge after the taking edge
    task automatic issue(input logic [5:0] idx, input logic [31:0] arg);
        cmd_valid = 1'b1; cmd_index = idx; cmd_arg = arg;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_index = 6'd0; cmd_arg = 32'd0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic sw(input logic [31:0] arg);
        issue(6'd6, arg);
    endtask

    task automatic t_reset();
        check("R1 busy", {31'd0, busy}, 0);
        check("R1 err", {31'd0, switch_err}, 0);
        check("R1 cmd_set", {29'd0, cmd_set}, 0);
        check_byte("R1 b175", 175, 8'h00);
        check_byte("R1 b183", 183, 8'h00);
        check_byte("R1 b185", 185, 8'h00);
        check_byte("R1 b192", 192, 8'h05);
        check_byte("R1 b194", 194, 8'h02);
        check_byte("R1 b196", 196, 8'h03);
        check_byte("R1 b212", 212, 8'h00);
        check_byte("R1 b213", 213, 8'h80);
        check_byte("R1 b214", 214, 8'hEC);
        check_byte("R1 b215", 215, 8'h00);
        check_byte("R1 b217", 217, 8'd17);
        check_byte("R1 b232", 232, 8'd32);
        check_byte("R12 b300", 300, 8'h00);
        check_byte("R12 b511", 511, 8'h00);
    endtask

    task automatic t_write_busy();
        int n = 0;
        sw(mk(2'd3, 8'd185, 8'h01, 3'd0));
        check_byte("R3 write b185", 185, 8'h01);
        check("R11 err after good", {31'd0, switch_err}, 0);
        while (busy) begin n++; @(negedge clk); end
        check("R10 busy length", n, 8);
    endtask

    task automatic t_ignore_while_busy();
        sw(mk(2'd3, 8'd185, 8'h03, 3'd0));
        sw(mk(2'd3, 8'd185, 8'h07, 3'd0));        // busy: dropped
        sw(32'hFC00_0000);                          // busy: dropped, err must stay 0
        check("R10 err unchanged while busy", {31'd0, switch_err}, 0);
        wait_idle();
        check_byte("R10 dropped write", 185, 8'h03);
        check("R10 busy clear", {31'd0, busy}, 0);
    endtask

    task automatic t_setbits();
        sw(mk(2'd1, 8'd175, 8'h05, 3'd0)); wait_idle();
        check_byte("R4 set 05", 175, 8'h05);
        sw(mk(2'd1, 8'd175, 8'h0A, 3'd0)); wait_idle();
        check_byte("R4 set 0A", 175, 8'h0F);
    endtask

    task automatic t_clrbits();
        sw(mk(2'd2, 8'd175, 8'h05, 3'd0)); wait_idle();
        check_byte("R5 clear 05", 175, 8'h0A);
    endtask

    task automatic t_cmdset();
        sw(mk(2'd0, 8'd185, 8'hFF, 3'd5));
        check("R6 cmd_set", {29'd0, cmd_set}, 5);
        wait_idle();
        check_byte("R6 array untouched", 185, 8'h03);
    endtask

    task automatic t_reserved();
        sw(mk(2'd3, 8'd185, 8'h01, 3'd0) | 32'h1000_0000);
        check("R7 err hi bit", {31'd0, switch_err}, 1);
        wait_idle();
        check_byte("R7 no change", 185, 8'h03);
        sw(mk(2'd3, 8'd175, 8'h01, 3'd0) | 32'h0000_0010);
        check("R7 err lo bit", {31'd0, switch_err}, 1);
        wait_idle();
        check_byte("R7 no change 175", 175, 8'h0A);
        sw(mk(2'd0, 8'd0, 8'd0, 3'd2) | 32'h0000_0080);
        check("R7 cmd_set kept", {29'd0, cmd_set}, 5);
        wait_idle();
        sw(mk(2'd3, 8'd185, 8'h00, 3'd0));
        check("R11 err cleared", {31'd0, switch_err}, 0);
        wait_idle();
    endtask

    task automatic t_readonly();
        sw(mk(2'd3, 8'd192, 8'h99, 3'd0));
        check("R8 err b192", {31'd0, switch_err}, 1);
        wait_idle();
        check_byte("R8 b192 kept", 192, 8'h05);
        sw(mk(2'd1, 8'd213, 8'h01, 3'd0));
        check("R8 err b213", {31'd0, switch_err}, 1);
        wait_idle();
        check_byte("R8 b213 kept", 213, 8'h80);
    endtask

    task automatic t_buswidth();
        sw(mk(2'd3, 8'd183, 8'h02, 3'd0)); wait_idle();
        check_byte("R9 write 2", 183, 8'h02);
        sw(mk(2'd3, 8'd183, 8'h03, 3'd0));
        check("R9 err code 3", {31'd0, switch_err}, 1);
        wait_idle();
        check_byte("R9 kept 2", 183, 8'h02);
        sw(mk(2'd3, 8'd183, 8'h06, 3'd0)); wait_idle();
        check("R9 code 6 ok", {31'd0, switch_err}, 0);
        sw(mk(2'd1, 8'd183, 8'h01, 3'd0));
        check("R9 err set to 7", {31'd0, switch_err}, 1);
        wait_idle();
        check_byte("R9 kept 6", 183, 8'h06);
        sw(mk(2'd2, 8'd183, 8'h04, 3'd0)); wait_idle();
        check_byte("R9 clear to 2", 183, 8'h02);
        check("R9 clear ok", {31'd0, switch_err}, 0);
    endtask

    task automatic t_other_index();
        issue(6'd7, mk(2'd3, 8'd185, 8'h55, 3'd0));
        check("R2 other index no busy", {31'd0, busy}, 0);
        check_byte("R2 other index no write", 185, 8'h00);
        cmd_index = 6'd6; cmd_arg = mk(2'd3, 8'd185, 8'h55, 3'd0);
        @(negedge clk);
        cmd_index = 6'd0; cmd_arg = 32'd0;
        check_byte("R2 no strobe no write", 185, 8'h00);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_busy();
        t_ignore_while_busy();
        t_setbits();
        t_clrbits();
        t_cmdset();
        t_reserved();
        t_readonly();
        t_buswidth();
        t_other_index();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule